// File: doc/BRIEF.md
# Buck Converter Fault Supervisor

This block is the digital supervisor for a single-phase synchronous buck controller. It runs on the system clock. A one-cycle `tick` pulse marks each switching period. The analog comparators sit outside the block and reach it as digitized flags. From those flags the supervisor decides when soft-start may begin, when the PWM may switch and when the linear regulator may be enabled. It also decides when the output is discharged and how each protection event is handled.

Current-limit and under-voltage events count consecutive switching periods. Both are masked until soft-start has climbed past its protection threshold. Once they persist long enough, they latch a fault that forces both gate drives off.

Over-voltage is handled differently. It is armed as soon as enable is high and needs only two consecutive periods. It then clamps the output through the low-side switch until the feedback falls below a release level. The crowbar alone does not latch a fault. A fault is latched only if the crowbar is active once soft-start has passed the protection threshold.

Over-temperature stops the converter and restarts it once the cool-down flag is seen. A latched fault either waits for enable to be toggled or a supply drop (latched mode), or restarts after a programmable number of switching periods (auto-restart mode).

Top module: `buck_fault_supervisor`

## Requirements
- R1: Soft-start is released (`ss_release`=1) and the PWM is enabled (`pwm_en`=1) only while the supply-good state is set and `en` is high. From reset all outputs are 0 except `dischg_en`=1.
- R2: The supply-good state sets when `vcc_above_on` is high and clears when `vcc_below_off` is high (clear wins). With both flags low it keeps its previous value.
- R3: While `ss_prot_ok` is low, `ilim_trip` and `fb_under` have no effect, however long they last.
- R4: `ldo_en` is high only while the converter is running and `ss_ldo_ok` is high.
- R5: `ilim_trip` sampled high on OC_TICKS (default 16) consecutive ticks latches an over-current fault. A tick with the flag low restarts the count.
- R6: `fb_under` sampled high on UV_TICKS (default 16) consecutive ticks latches an under-voltage fault.
- R7: `fb_over` sampled high on OV_TICKS (default 2) consecutive ticks sets the crowbar. The crowbar drives `ls_crowbar`=1 and `pwm_en`=0 until `fb_release` is high, and stays set while `fb_release` is low.
- R8: Over-voltage is armed whenever `en` is high, including during soft-start. It latches an over-voltage fault only if the crowbar is set while `ss_prot_ok` is high.
- R9: In the fault state, and in the over-temperature state, `drv_off`=1 whenever the crowbar is not set. While the crowbar is set, `drv_off`=0 and `ls_crowbar`=1.
- R10: A latched fault clears only when `en` goes low or the supply-good state clears. Until then the fault state and the code stay put.
- R11: `dischg_en` is the inverse of `pwm_en`.
- R12: `temp_hot` stops the converter and holds it off, and also blocks start-up. After `temp_cool` is seen, the converter restarts without any other action.
- R13: With `auto_restart`=1, a latched fault returns to start-up on the RESTART_TICKS-th tick after entry. With `auto_restart`=0 it stays latched.
- R14: `fault_code` gives the latched cause: 2'b00 none, 2'b01 over-current, 2'b10 under-voltage, 2'b11 over-voltage. If more than one cause is pending at once, over-voltage is chosen first, then over-current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per switching period |
| auto_restart | input | 1 | 1: restart after fault delay; 0: stay latched |
| en | input | 1 | Converter enable |
| vcc_above_on | input | 1 | Supply above rising lockout threshold |
| vcc_below_off | input | 1 | Supply below falling lockout threshold |
| ss_prot_ok | input | 1 | Soft-start above protection-arm level |
| ss_ldo_ok | input | 1 | Soft-start above linear-regulator start level |
| ilim_trip | input | 1 | Current-limit comparator tripped |
| fb_under | input | 1 | Feedback below under-voltage level |
| fb_over | input | 1 | Feedback above over-voltage level |
| fb_release | input | 1 | Feedback below crowbar release level |
| temp_hot | input | 1 | Die temperature above trip |
| temp_cool | input | 1 | Die temperature back below restart level |
| pwm_en | output | 1 | PWM switching allowed |
| drv_off | output | 1 | Force both gate drives off |
| ls_crowbar | output | 1 | Force low-side switch on |
| ldo_en | output | 1 | Linear regulator enable |
| ss_release | output | 1 | Release the soft-start capacitor |
| dischg_en | output | 1 | Output discharge pull-down on |
| fault_code | output | 2 | Latched fault cause |

## Verification
The bench keeps OC_TICKS and UV_TICKS at 16 and OV_TICKS at 2. These are the real persistence windows, so the runs of 15 and 16 periods test the exact boundary of each counter. RESTART_TICKS is lowered to 5. This brings the auto-restart exit into a short run, and the checks land on the fourth tick (still latched) and the fifth tick (restarted). The latched-mode table also covers the following:
- the lockout band between the two thresholds;
- an over-voltage crowbar that releases without a fault before protection is armed;
- the same crowbar that latches a fault once protection is armed;
- thermal shutdown with automatic recovery.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_RUN   = 2'b01,
    ST_FAULT = 2'b10,
    ST_HOT   = 2'b11
  } sup_state_e;

  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_OC   = 2'b01,
    FC_UV   = 2'b10,
    FC_OV   = 2'b11
  } fault_code_e;
endpackage

// File: rtl/bfs_supply_latch.sv
module bfs_supply_latch (
  input  logic clk,
  input  logic rst,
  input  logic above_on,
  input  logic below_off,
  output logic supply_ok
);
  // Hysteretic supply-good state: the falling flag has priority.
  always_ff @(posedge clk) begin
    if (rst)            supply_ok <= 1'b0;
    else if (below_off) supply_ok <= 1'b0;
    else if (above_on)  supply_ok <= 1'b1;
  end

  AST_UVLO_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(below_off) |-> !supply_ok); // R2
endmodule

// File: rtl/bfs_persist_cnt.sv
module bfs_persist_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic cond,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt;

  // Counts switching periods in which the flag was high, back to back.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      if (!cond)              cnt <= '0;
      else if (cnt != LIM_V)  cnt <= cnt + 1'b1;
    end
  end

  assign hit = (cnt == LIM_V);

  AST_CLEAN_TICK_RESETS: assert property (@(posedge clk) disable iff (rst)
    $past(tick && !cond && !clr) |-> !hit); // R5
endmodule

// File: rtl/bfs_restart_timer.sv
module bfs_restart_timer #(
  parameter int TICKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)          cnt <= '0;
    else if (tick && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && tick && (cnt == LAST);
endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
  import bfs_pkg::*;
#(
  parameter int OC_TICKS      = 16,
  parameter int UV_TICKS      = 16,
  parameter int OV_TICKS      = 2,
  parameter int RESTART_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       auto_restart,
  input  logic       en,
  input  logic       vcc_above_on,
  input  logic       vcc_below_off,
  input  logic       ss_prot_ok,
  input  logic       ss_ldo_ok,
  input  logic       ilim_trip,
  input  logic       fb_under,
  input  logic       fb_over,
  input  logic       fb_release,
  input  logic       temp_hot,
  input  logic       temp_cool,
  output logic       pwm_en,
  output logic       drv_off,
  output logic       ls_crowbar,
  output logic       ldo_en,
  output logic       ss_release,
  output logic       dischg_en,
  output logic [1:0] fault_code
);
  sup_state_e  st, st_n;
  fault_code_e code, code_n;
  logic supply_ok;
  logic oc_hit, uv_hit, ov_hit;
  logic crowbar;
  logic restart_done;
  logic prot_clr;

  bfs_supply_latch u_supply (
    .clk       (clk),
    .rst       (rst),
    .above_on  (vcc_above_on),
    .below_off (vcc_below_off),
    .supply_ok (supply_ok)
  );

  // Current and under-voltage counting only while running and armed.
  assign prot_clr = (st != ST_RUN) || !ss_prot_ok;

  bfs_persist_cnt #(.LIMIT(OC_TICKS)) u_oc_cnt (
    .clk(clk), .rst(rst), .clr(prot_clr), .tick(tick), .cond(ilim_trip), .hit(oc_hit)
  );

  bfs_persist_cnt #(.LIMIT(UV_TICKS)) u_uv_cnt (
    .clk(clk), .rst(rst), .clr(prot_clr), .tick(tick), .cond(fb_under), .hit(uv_hit)
  );

  // Over-voltage is armed by enable alone.
  bfs_persist_cnt #(.LIMIT(OV_TICKS)) u_ov_cnt (
    .clk(clk), .rst(rst), .clr(!en), .tick(tick), .cond(fb_over), .hit(ov_hit)
  );

  bfs_restart_timer #(.TICKS(RESTART_TICKS)) u_restart (
    .clk  (clk),
    .rst  (rst),
    .run  ((st == ST_FAULT) && auto_restart),
    .tick (tick),
    .done (restart_done)
  );

  // Crowbar: release level has priority over a still-high detector.
  always_ff @(posedge clk) begin
    if (rst)             crowbar <= 1'b0;
    else if (fb_release) crowbar <= 1'b0;
    else if (ov_hit)     crowbar <= 1'b1;
  end

  always_comb begin
    st_n   = st;
    code_n = code;
    if (!supply_ok || !en) begin
      st_n   = ST_OFF;
      code_n = FC_NONE;
    end else begin
      unique case (st)
        ST_OFF: if (!temp_hot) st_n = ST_RUN;
        ST_RUN: begin
          if (temp_hot) begin
            st_n = ST_HOT;
          end else if (crowbar && ss_prot_ok) begin
            st_n = ST_FAULT; code_n = FC_OV;
          end else if (oc_hit) begin
            st_n = ST_FAULT; code_n = FC_OC;
          end else if (uv_hit) begin
            st_n = ST_FAULT; code_n = FC_UV;
          end
        end
        ST_FAULT: if (restart_done) begin
          st_n = ST_OFF; code_n = FC_NONE;
        end
        ST_HOT: if (temp_cool) st_n = ST_OFF;
        default: st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_OFF;
      code <= FC_NONE;
    end else begin
      st   <= st_n;
      code <= code_n;
    end
  end

  // Registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_en     <= 1'b0;
      drv_off    <= 1'b0;
      ls_crowbar <= 1'b0;
      ldo_en     <= 1'b0;
      ss_release <= 1'b0;
      dischg_en  <= 1'b1;
    end else begin
      pwm_en     <= (st == ST_RUN) && !crowbar;
      drv_off    <= ((st == ST_FAULT) || (st == ST_HOT)) && !crowbar;
      ls_crowbar <= crowbar;
      ldo_en     <= (st == ST_RUN) && ss_ldo_ok;
      ss_release <= (st == ST_RUN);
      dischg_en  <= !((st == ST_RUN) && !crowbar);
    end
  end

  assign fault_code = code;

  AST_RELEASE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_release) |-> $past(en, 2)); // R1
  AST_LDO_GATED: assert property (@(posedge clk) disable iff (rst)
    ldo_en |-> $past(ss_ldo_ok)); // R4
  AST_CROWBAR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(ls_crowbar) |-> $past(fb_release, 2)); // R7
  AST_OC_MASKED: assert property (@(posedge clk) disable iff (rst)
    (fault_code == 2'b01) && ($past(fault_code) != 2'b01) |-> $past(ss_prot_ok, 2)); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FAULT) && !auto_restart && en && supply_ok |=> (st == ST_FAULT)); // R10
  AST_DISCHG_OPPOSES_PWM: assert property (@(posedge clk) disable iff (rst)
    pwm_en |-> !dischg_en); // R11
endmodule

// File: tb/test_buck_fault_supervisor.sv
`timescale 1ns/1ps
module test_buck_fault_supervisor;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, tick, auto_restart;
  logic en, vcc_above_on, vcc_below_off, ss_prot_ok, ss_ldo_ok;
  logic ilim_trip, fb_under, fb_over, fb_release, temp_hot, temp_cool;
  logic pwm_en, drv_off, ls_crowbar, ldo_en, ss_release, dischg_en;
  logic [1:0] fault_code;

  buck_fault_supervisor #(
    .OC_TICKS(16), .UV_TICKS(16), .OV_TICKS(2), .RESTART_TICKS(5)
  ) i_buck_fault_supervisor (
    .clk(clk), .rst(rst), .tick(tick), .auto_restart(auto_restart), .en(en),
    .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
    .ss_prot_ok(ss_prot_ok), .ss_ldo_ok(ss_ldo_ok), .ilim_trip(ilim_trip),
    .fb_under(fb_under), .fb_over(fb_over), .fb_release(fb_release),
    .temp_hot(temp_hot), .temp_cool(temp_cool), .pwm_en(pwm_en),
    .drv_off(drv_off), .ls_crowbar(ls_crowbar), .ldo_en(ldo_en),
    .ss_release(ss_release), .dischg_en(dischg_en), .fault_code(fault_code)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Vector: {req, stim, ticks, expected}
  // stim  = {en, above_on, below_off, ss_prot, ss_ldo, ilim, fb_under, fb_over, fb_release, hot, cool}
  // expect = {pwm_en, drv_off, ls_crowbar, ldo_en, ss_release, dischg_en, fault_code[1:0]}
  localparam int NV = 28;
  localparam logic [27:0] VEC [NV] = '{
    {4'd1,  11'b000_00_0000_00, 5'd2,  8'b000001_00}, // R1 nothing enabled
    {4'd1,  11'b101_00_0000_00, 5'd2,  8'b000001_00}, // R1 enable but supply low
    {4'd2,  11'b110_00_0000_00, 5'd2,  8'b100010_00}, // R2 supply rises -> run
    {4'd2,  11'b100_00_0000_00, 5'd2,  8'b100010_00}, // R2 inside hysteresis band
    {4'd4,  11'b100_01_0000_00, 5'd2,  8'b100110_00}, // R4 LDO level reached
    {4'd3,  11'b100_01_1000_00, 5'd20, 8'b100110_00}, // R3 current limit masked
    {4'd5,  11'b100_11_1000_00, 5'd15, 8'b100110_00}, // R5 15 periods: no fault
    {4'd5,  11'b100_11_0000_00, 5'd1,  8'b100110_00}, // R5 one clean period
    {4'd5,  11'b100_11_1000_00, 5'd15, 8'b100110_00}, // R5 count restarted
    {4'd14, 11'b100_11_1000_00, 5'd1,  8'b010001_01}, // R5 R14 16th period -> OC
    {4'd10, 11'b100_11_0000_00, 5'd4,  8'b010001_01}, // R10 stays latched
    {4'd10, 11'b010_00_0000_00, 5'd2,  8'b000001_00}, // R10 enable low clears
    {4'd6,  11'b110_10_0100_00, 5'd15, 8'b100010_00}, // R6 15 periods under
    {4'd6,  11'b110_10_0100_00, 5'd1,  8'b010001_10}, // R6 R14 UV fault
    {4'd10, 11'b101_00_0000_00, 5'd2,  8'b000001_00}, // R10 supply drop clears
    {4'd2,  11'b100_00_0000_00, 5'd2,  8'b000001_00}, // R2 band: stays off
    {4'd7,  11'b110_00_0010_00, 5'd1,  8'b100010_00}, // R7 one OV period
    {4'd8,  11'b110_00_0010_00, 5'd1,  8'b001011_00}, // R7 R8 crowbar, no fault
    {4'd7,  11'b110_00_0000_00, 5'd3,  8'b001011_00}, // R7 crowbar holds
    {4'd7,  11'b110_00_0001_00, 5'd2,  8'b100010_00}, // R7 release level
    {4'd8,  11'b110_10_0010_00, 5'd2,  8'b001001_11}, // R8 R14 armed -> OV fault
    {4'd9,  11'b110_10_0001_00, 5'd2,  8'b010001_11}, // R9 both drives off
    {4'd10, 11'b010_00_0000_00, 5'd2,  8'b000001_00}, // R10 enable low clears
    {4'd12, 11'b110_00_0000_10, 5'd2,  8'b000001_00}, // R12 hot blocks start
    {4'd12, 11'b110_00_0000_00, 5'd2,  8'b100010_00}, // R12 starts
    {4'd12, 11'b110_00_0000_10, 5'd2,  8'b010001_00}, // R12 hot shutdown
    {4'd12, 11'b110_00_0000_00, 5'd2,  8'b010001_00}, // R12 waits for cool
    {4'd12, 11'b110_00_0000_01, 5'd2,  8'b100010_00}  // R12 cool -> restart
  };

  function automatic logic [7:0] outs();
    return {pwm_en, drv_off, ls_crowbar, ldo_en, ss_release, dischg_en, fault_code};
  endfunction

  task automatic check(input logic [7:0] exp, input int req, input string what);
    checks++;
    if (outs() !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, outs(), exp);
    end
  endtask

  task automatic apply(input logic [10:0] s);
    {en, vcc_above_on, vcc_below_off, ss_prot_ok, ss_ldo_ok, ilim_trip,
     fb_under, fb_over, fb_release, temp_hot, temp_cool} = s;
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; tick = 1'b0; auto_restart = 1'b0;
    apply(11'b0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(8'b000001_00, 1, "reset state"); // R1 R11

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][23:13]);
      run_ticks(int'(VEC[i][12:8]));
      check(VEC[i][7:0], int'(VEC[i][27:24]), $sformatf("vector %0d", i));
    end

    // R13 auto-restart: fault, hold for 4 periods, restart on the 5th.
    auto_restart = 1'b1;
    apply(11'b110_10_1000_00);
    run_ticks(16);
    check(8'b010001_01, 13, "auto mode fault latched");
    apply(11'b110_10_0000_00);
    run_ticks(4);
    check(8'b010001_01, 13, "auto mode still waiting");
    run_ticks(1);
    check(8'b100010_00, 13, "auto mode restarted");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule